// File: doc/BRIEF.md
# Prescaled Single-Channel PWM Timer

This block is one PWM channel that a processor programs over a small 32-bit register bus. A power-of-two prescaler slows the input clock down. Each slowed clock step advances a 10-bit counter that runs from zero up to a programmed period count and then wraps. The output is high while that counter is below a programmed high-time count. The period, the high time and the prescaler exponent therefore set the waveform together.

The bus has two word-addressed registers. Word 0 (byte offset 0x00) is the control register and word 1 (byte offset 0x04) is the counter register. Reads are combinational and return the programmed values.

A hold bit lets software change all three waveform parameters at once. While hold is set, writes only reach shadow copies. Clearing hold makes the shadow copies take effect together at the next period boundary, so no period ever mixes old and new values.

Top module: `pwm_prescale_timer`

The register-side controller has three states:
- RF_DIRECT, the reset state: writes reach the shadow and active copies at once.
- RF_HOLD: writes reach the shadow copies only.
- RF_PENDING: the controller waits for a boundary and then copies shadow to active.

Its transitions are:
- DIRECT to HOLD on a control write with hold set.
- HOLD to PENDING on a control write with hold clear.
- PENDING back to HOLD on a control write with hold set.
- PENDING to DIRECT on commit, which happens at a period boundary or at once when the waveform is idle.

The waveform side also has three states:
- WV_IDLE: output low, counters cleared.
- WV_HIGH: output high.
- WV_LOW: output low.

Its transitions are:
- IDLE to HIGH one clock after the channel becomes runnable.
- HIGH to LOW when the incremented count reaches the high time.
- HIGH or LOW back to HIGH at the period wrap.
- Any state to IDLE when the channel is not runnable.

## Requirements
- R1: After reset the output is low and both registers read zero.
- R2: The control register is laid out as follows, with all other bits reading zero:
  - bit 0: enable;
  - bit 4: source select, stored and read back only;
  - bit 11: hold;
  - bit 15: half-step;
  - bits 19:16: coarse divide.
  The counter register holds the period count in bits 25:16 and the high-time count in bits 9:0, with all other bits reading zero.
- R3: With exponent n = 2*coarse + half, each count step lasts 2^n clocks. The output is high for high*2^n clocks out of every period*2^n clocks.
- R4: If the high-time count is greater than or equal to the period count, the output stays high continuously.
- R5: If enable is 0, or either active count is 0, the output is low and the counter and prescaler are held cleared. After the write that makes the channel runnable, the output goes high in the following clock and starts a fresh period.
- R6: While hold reads 1, writes to the counter register and to the divide fields change only the read-back values, not the waveform. The hold state used for a write is the one before that write.
- R7: After hold is cleared, the new period, high time and exponent all take effect together from the next period boundary.
- R8: Exponents above the MAX_EXP parameter (24 by default) are clamped to MAX_EXP, while reads still return the programmed fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | ADDR_W | Word address: 0 control, 1 counter |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| pwm_out | output | 1 | PWM waveform |

## Verification
If the prescaler or the period counter is in a wrong state, the port shows high and low run lengths that differ from high*2^n and period*2^n. That error is visible within one output period of sync. If the shadow or active copies are wrong, one of two things appears:
- the read-back value differs from the write at once;
- the waveform changes while hold is set, or is still old one period after hold is released.

Errors in the enable or zero-count logic show as a high output, or a missing rise, within two clocks of the enabling write.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;
    localparam int F_EN       = 0;
    localparam int F_SRC      = 4;
    localparam int F_HOLD     = 11;
    localparam int F_HALF     = 15;
    localparam int F_COARSE   = 16;
    localparam int COARSE_W   = 4;
    localparam int EXP_W      = COARSE_W + 1;
    localparam int PER_LSB    = 16;
    localparam int HIGH_LSB   = 0;

    typedef enum logic [1:0] {
        RF_DIRECT  = 2'd0,
        RF_HOLD    = 2'd1,
        RF_PENDING = 2'd2
    } reg_state_t;

    typedef enum logic [1:0] {
        WV_IDLE = 2'd0,
        WV_HIGH = 2'd1,
        WV_LOW  = 2'd2
    } wave_state_t;
endpackage

// File: rtl/pwm_regs.sv
module pwm_regs
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int MAX_EXP = 24,
    parameter int ADDR_W  = 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bus_sel,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [31:0]         bus_wdata,
    output logic [31:0]         bus_rdata,
    input  logic                boundary,
    input  logic                wave_busy,
    output logic                en_q,
    output logic [CNT_W-1:0]    act_per,
    output logic [CNT_W-1:0]    act_high,
    output logic [EXP_W-1:0]    act_exp,
    output logic                hold_on,
    output logic                pending
);
    reg_state_t state, state_d;

    logic [COARSE_W-1:0] sh_coarse, sh_coarse_d, act_coarse;
    logic                sh_half, sh_half_d, act_half;
    logic [CNT_W-1:0]    sh_per, sh_per_d, sh_high, sh_high_d;
    logic                src_q;
    logic                wr_ctrl, wr_cnt, commit_now, load_act;
    logic [EXP_W-1:0]    exp_raw;
    logic                unused_wdata;

    assign unused_wdata = ^bus_wdata;
    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == ADDR_W'(0));
    assign wr_cnt  = bus_sel && bus_wr && (bus_addr == ADDR_W'(1));

    assign commit_now = (state == RF_PENDING) && (boundary || !wave_busy);
    assign load_act   = (state == RF_DIRECT) || commit_now;
    assign hold_on    = (state == RF_HOLD);
    assign pending    = (state == RF_PENDING);

    // next-state process for the update controller
    always_comb begin
        state_d = state;
        unique case (state)
            RF_DIRECT:  if (wr_ctrl && bus_wdata[F_HOLD]) state_d = RF_HOLD;
            RF_HOLD:    if (wr_ctrl && !bus_wdata[F_HOLD]) state_d = RF_PENDING;
            RF_PENDING: begin
                if (wr_ctrl && bus_wdata[F_HOLD]) state_d = RF_HOLD;
                else if (commit_now)              state_d = RF_DIRECT;
            end
            default:    state_d = RF_DIRECT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RF_DIRECT;
        else        state <= state_d;
    end

    // shadow values after this cycle's write
    always_comb begin
        sh_coarse_d = sh_coarse;
        sh_half_d   = sh_half;
        sh_per_d    = sh_per;
        sh_high_d   = sh_high;
        if (wr_ctrl) begin
            sh_coarse_d = bus_wdata[F_COARSE +: COARSE_W];
            sh_half_d   = bus_wdata[F_HALF];
        end
        if (wr_cnt) begin
            sh_per_d  = bus_wdata[PER_LSB  +: CNT_W];
            sh_high_d = bus_wdata[HIGH_LSB +: CNT_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_coarse  <= '0;
            sh_half    <= 1'b0;
            sh_per     <= '0;
            sh_high    <= '0;
            en_q       <= 1'b0;
            src_q      <= 1'b0;
            act_coarse <= '0;
            act_half   <= 1'b0;
            act_per    <= '0;
            act_high   <= '0;
        end else begin
            sh_coarse <= sh_coarse_d;
            sh_half   <= sh_half_d;
            sh_per    <= sh_per_d;
            sh_high   <= sh_high_d;
            if (wr_ctrl) begin
                en_q  <= bus_wdata[F_EN];
                src_q <= bus_wdata[F_SRC];
            end
            if (load_act) begin
                act_coarse <= sh_coarse_d;
                act_half   <= sh_half_d;
                act_per    <= sh_per_d;
                act_high   <= sh_high_d;
            end
        end
    end

    // exponent 2*coarse + half, clamped
    assign exp_raw = {act_coarse, act_half};
    always_comb begin
        if (int'(exp_raw) > MAX_EXP) act_exp = EXP_W'(MAX_EXP);
        else                         act_exp = exp_raw;
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(0)) begin
            bus_rdata[F_EN]                  = en_q;
            bus_rdata[F_SRC]                 = src_q;
            bus_rdata[F_HOLD]                = hold_on;
            bus_rdata[F_HALF]                = sh_half;
            bus_rdata[F_COARSE +: COARSE_W]  = sh_coarse;
        end else if (bus_addr == ADDR_W'(1)) begin
            bus_rdata[PER_LSB  +: CNT_W]     = sh_per;
            bus_rdata[HIGH_LSB +: CNT_W]     = sh_high;
        end
    end
endmodule

// File: rtl/pwm_prescaler.sv
module pwm_prescaler
    import pwm_timer_pkg::*;
#(
    parameter int MAX_EXP = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic [EXP_W-1:0] exp_sel,
    output logic             tick
);
    localparam int PS_W = (MAX_EXP > 0) ? MAX_EXP : 1;

    logic [PS_W-1:0] ps_cnt;
    logic [PS_W-1:0] mask;

    assign mask = ~({PS_W{1'b1}} << exp_sel);
    assign tick = run && ((ps_cnt & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                ps_cnt <= '0;
        else if (!run || restart)  ps_cnt <= '0;
        else                       ps_cnt <= ps_cnt + PS_W'(1);
    end
endmodule

// File: rtl/pwm_wave.sv
module pwm_wave
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic [CNT_W-1:0] per,
    input  logic [CNT_W-1:0] high,
    input  logic             tick,
    output logic             run,
    output logic             busy,
    output logic             boundary,
    output logic             pwm_out
);
    wave_state_t       st, st_d;
    logic [CNT_W-1:0]  cnt, cnt_d;
    logic [CNT_W:0]    cnt_inc;

    assign run     = en && (per != '0) && (high != '0);
    assign busy    = (st != WV_IDLE);
    assign cnt_inc = {1'b0, cnt} + (CNT_W+1)'(1);

    always_comb begin
        st_d     = st;
        cnt_d    = cnt;
        boundary = 1'b0;
        if (!run) begin
            st_d  = WV_IDLE;
            cnt_d = '0;
        end else begin
            unique case (st)
                WV_IDLE: begin
                    st_d  = WV_HIGH;
                    cnt_d = '0;
                end
                WV_HIGH, WV_LOW: begin
                    if (tick) begin
                        if (cnt_inc >= {1'b0, per}) begin
                            boundary = 1'b1;
                            cnt_d    = '0;
                            st_d     = WV_HIGH;
                        end else begin
                            cnt_d = cnt_inc[CNT_W-1:0];
                            st_d  = (cnt_inc < {1'b0, high}) ? WV_HIGH : WV_LOW;
                        end
                    end
                end
                default: st_d = WV_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= WV_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_d;
            cnt <= cnt_d;
        end
    end

    // output process
    always_comb begin
        pwm_out = (st == WV_HIGH);
    end
endmodule

// File: rtl/pwm_prescale_timer.sv
module pwm_prescale_timer
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int MAX_EXP = 24,
    parameter int ADDR_W  = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              pwm_out
);
    logic             en_q, hold_on, pending;
    logic [CNT_W-1:0] act_per, act_high;
    logic [EXP_W-1:0] act_exp;
    logic             run, busy, boundary, tick;

    pwm_regs #(.CNT_W(CNT_W), .MAX_EXP(MAX_EXP), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .boundary(boundary), .wave_busy(busy),
        .en_q(en_q), .act_per(act_per), .act_high(act_high),
        .act_exp(act_exp), .hold_on(hold_on), .pending(pending)
    );

    pwm_prescaler #(.MAX_EXP(MAX_EXP)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(busy), .restart(boundary),
        .exp_sel(act_exp), .tick(tick)
    );

    pwm_wave #(.CNT_W(CNT_W)) u_wave (
        .clk(clk), .rst_n(rst_n), .en(en_q), .per(act_per),
        .high(act_high), .tick(tick), .run(run), .busy(busy),
        .boundary(boundary), .pwm_out(pwm_out)
    );
endmodule

// File: rtl/pwm_timer_chk.sv
module pwm_timer_chk
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W   = 10,
    parameter int MAX_EXP = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pwm_out,
    input logic             run,
    input logic             busy,
    input logic             tick,
    input logic             boundary,
    input logic             pending,
    input logic             hold_on,
    input logic [CNT_W-1:0] act_per,
    input logic [CNT_W-1:0] act_high,
    input logic [EXP_W-1:0] act_exp
);
    localparam int GAP_W = MAX_EXP + 2;
    logic [GAP_W-1:0] gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             gap <= '0;
        else if (!busy || tick) gap <= '0;
        else                    gap <= gap + GAP_W'(1);
    end

    always @(posedge clk) begin
        if (!rst_n) a_reset_low_r1: assert (!pwm_out);
    end

    p_full_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy && run && (act_high >= act_per) |=> pwm_out);

    p_idle_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !pwm_out);

    p_hold_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
        hold_on |=> $stable(act_per) && $stable(act_high) && $stable(act_exp));

    p_wait_boundary_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pending && busy && !boundary |=>
            $stable(act_per) && $stable(act_high) && $stable(act_exp));

    p_tick_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (gap < GAP_W'(2 ** MAX_EXP)));
endmodule

bind pwm_prescale_timer pwm_timer_chk #(.CNT_W(CNT_W), .MAX_EXP(MAX_EXP)) u_chk (
    .clk(clk), .rst_n(rst_n), .pwm_out(pwm_out), .run(run), .busy(busy),
    .tick(tick), .boundary(boundary), .pending(pending), .hold_on(hold_on),
    .act_per(act_per), .act_high(act_high), .act_exp(act_exp)
);

// File: tb/test_pwm_prescale_timer.sv
`timescale 1ns/1ps
module test_pwm_prescale_timer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [0:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata, unused_rd_c;
    logic        pwm_out, pwm_c;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;
    localparam int LIM = 5000;

    always #2 clk = ~clk;

    pwm_prescale_timer i_pwm_prescale_timer (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out));

    pwm_prescale_timer #(.MAX_EXP(3)) i_pwm_prescale_timer_clamp (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(unused_rd_c),
        .pwm_out(pwm_c));

    // R3/R4 vectors: control word, counter word, expected high clocks, expected period clocks
    localparam int NV = 8;
    localparam logic [31:0] V_CTRL [NV] = '{32'h0000_0001, 32'h0000_8001, 32'h0001_0001,
        32'h0001_8001, 32'h0002_0001, 32'h0000_0001, 32'h0002_8001, 32'h0000_0001};
    localparam logic [31:0] V_CNT [NV] = '{32'h0004_0001, 32'h0005_0002, 32'h0003_0002,
        32'h0006_0003, 32'h0002_0001, 32'h03FF_03E8, 32'h0003_0001, 32'h0007_0009};
    localparam int V_HI  [NV] = '{1, 4, 8, 24, 16, 1000, 32, 7};
    localparam int V_PER [NV] = '{4, 10, 12, 48, 32, 1023, 96, 7};

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic bus_write(input logic a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    function automatic logic pick(input bit which);
        return which ? pwm_c : pwm_out;
    endfunction

    task automatic measure(input bit which, output int hi, output int per);
        int g = 0;
        int lo = 0;
        hi = 0;
        while (pick(which) && g < LIM) begin @(negedge clk); g++; end
        while (!pick(which) && g < LIM) begin @(negedge clk); g++; end
        while (pick(which) && g < LIM) begin @(negedge clk); g++; hi++; end
        while (!pick(which) && g < LIM) begin @(negedge clk); g++; lo++; end
        per = hi + lo;
    endtask

    task automatic count_high(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pwm_out) c++;
        end
    endtask

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            report();
        end
    end

    initial begin
        logic [31:0] rd;
        int hi, per, c;

        // R1: reset state
        repeat (3) @(negedge clk);
        check("R1 output", int'(pwm_out), 0);
        rst_n = 1'b1;
        bus_read(1'b0, rd); check("R1 ctrl read", int'(rd), 0);
        bus_read(1'b1, rd); check("R1 cnt read", int'(rd), 0);

        // R2: field layout, unused bits read zero
        bus_write(1'b0, 32'hFFFF_FFFE);
        bus_read(1'b0, rd); check("R2 ctrl layout", int'(rd), int'(32'h000F_8810));
        bus_write(1'b1, 32'hFFFF_FFFF);
        bus_read(1'b1, rd); check("R2 cnt layout", int'(rd), int'(32'h03FF_03FF));
        bus_write(1'b0, 32'h0);
        bus_read(1'b0, rd); check("R2 hold cleared", int'(rd), 0);

        // R3 and R4: vector table
        for (int v = 0; v < NV; v++) begin
            bus_write(1'b0, 32'h0);
            bus_write(1'b1, V_CNT[v]);
            bus_write(1'b0, V_CTRL[v]);
            if (V_HI[v] == V_PER[v]) begin
                repeat (2) @(negedge clk);
                count_high(3 * V_PER[v], c);
                check("R4 constant high", c, 3 * V_PER[v]);
            end else begin
                measure(1'b0, hi, per);
                check("R3 high clocks", hi, V_HI[v]);
                check("R3 period clocks", per, V_PER[v]);
            end
        end

        // R5: zero counts keep output low
        bus_write(1'b0, 32'h0);
        bus_write(1'b1, 32'h0004_0000);
        bus_write(1'b0, 32'h1);
        count_high(40, c); check("R5 zero high time", c, 0);
        bus_write(1'b1, 32'h0000_0003);
        count_high(40, c); check("R5 zero period", c, 0);

        // R5: start timing and disable
        bus_write(1'b0, 32'h0);
        bus_write(1'b1, 32'h0004_0001);
        bus_write(1'b0, 32'h1);
        check("R5 low right after enable write", int'(pwm_out), 0);
        @(negedge clk); check("R5 high one clock later", int'(pwm_out), 1);
        @(negedge clk); check("R5 low after first count", int'(pwm_out), 0);
        bus_write(1'b0, 32'h0);
        count_high(20, c); check("R5 disabled low", c, 0);

        // R6: hold keeps waveform while shadow changes
        bus_write(1'b1, 32'h0004_0001);
        bus_write(1'b0, 32'h1);
        measure(1'b0, hi, per);
        check("R6 baseline high", hi, 1); check("R6 baseline period", per, 4);
        bus_write(1'b0, 32'h0000_0801);
        bus_write(1'b0, 32'h0001_0801);
        bus_write(1'b1, 32'h0008_0006);
        bus_read(1'b0, rd); check("R6 ctrl shadow read", int'(rd), int'(32'h0001_0801));
        bus_read(1'b1, rd); check("R6 cnt shadow read", int'(rd), int'(32'h0008_0006));
        measure(1'b0, hi, per);
        check("R6 held high", hi, 1); check("R6 held period", per, 4);

        // R7: release commits all three together
        bus_write(1'b0, 32'h0001_0001);
        measure(1'b0, hi, per);
        check("R7 new high", hi, 24); check("R7 new period", per, 32);

        // R8: clamp on the MAX_EXP=3 instance, exponent 5 programmed
        bus_write(1'b0, 32'h0);
        bus_write(1'b1, 32'h0003_0001);
        bus_write(1'b0, 32'h0002_8001);
        bus_read(1'b0, rd); check("R8 programmed fields read", int'(rd), int'(32'h0002_8001));
        measure(1'b1, hi, per);
        check("R8 clamped high", hi, 8); check("R8 clamped period", per, 24);
        measure(1'b0, hi, per);
        check("R8 unclamped high", hi, 32); check("R8 unclamped period", per, 96);

        done = 1'b1;
        report();
    end
endmodule